// File: doc/BRIEF.md
# Four-bit adaptive differential speech codec

This block turns signed 8-bit speech samples into 4-bit adaptive differential codes and turns such codes back into 8-bit samples. Work happens once per sample strobe: in encode mode the strobe takes one sample and yields one code, and in decode mode it takes one code and updates the reconstructed sample. The encoder keeps its own reconstruction of what a decoder will rebuild, so an encoder and a decoder fed the same code stream stay in lock-step, bit for bit.

Each direction holds its own predictor, its own step index and the step size that index selects. The predictor is a fixed-point value with 8 fractional bits. The step size comes from a 34-entry geometric table. The index moves down slowly after small codes and jumps up after large ones, so the quantizer widens quickly on loud passages and narrows gradually on quiet ones. All scaling uses shifts and adds, with no multiplier. A run-start input returns the selected direction to its initial state at the beginning of a recording or playback run.

Top module: `adpcm4_codec`

## Requirements
- R1: After reset, code_out is 0, code_valid and pcm_valid are 0, and pcm_out is 128, which is the zero level.
- R2: In encode mode, bit 3 of the code is the sign. It is 1 exactly when pcm_in×256, with pcm_in read as two's complement, is less than the encoder predictor.
- R3: Code bits [2:0] come from successive comparison of the absolute difference A. Bit 2 = (A ≥ step), and if it is set, step is subtracted from A. Bit 1 = (A ≥ step/2), and if it is set, step/2 is subtracted. Bit 0 = (A ≥ step/4).
- R4: The reconstructed difference is step/8, plus step/4 if bit 0 is set, plus step/2 if bit 1 is set, plus step if bit 2 is set. It is subtracted from the predictor when bit 3 is set and added otherwise.
- R5: The predictor saturates at +127×256 and −127×256, so pcm_out always lies between 1 and 255.
- R6: The step is T[i]×256, where T is the geometric table 7,8,8,9,10,11,12,13,14,15,17,18,20,22,24,26,29,31,34,37,41,44,48,53,58,63,69,75,82,89,98,107,116,127 and i is the index. After each code, i changes by −1 for magnitudes 0 to 3 and by +2, +4, +6 or +8 for magnitudes 4, 5, 6 or 7. It is then clamped to 0..33.
- R7: run_start sets the predictor and index of the direction chosen by mode (0 encode, 1 decode) to zero. The other direction is untouched. A strobe in the same cycle is ignored and raises no valid.
- R8: A decode strobe (mode 1) raises pcm_valid for one cycle on the following cycle. pcm_out always shows floor(decoder predictor / 256) + 128 as an unsigned byte.
- R9: An encode strobe (mode 0) raises code_valid for one cycle on the following cycle, with the new code on code_out. Without a strobe, code_out holds and neither direction's state changes.
- R10: When the encoder's codes are fed to the decoder, the decoder's pcm_out equals the encoder's own reconstruction after every code. Strobes in one mode leave the other mode's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_start | input | 1 | Restarts the direction selected by mode |
| mode | input | 1 | 0 = encode, 1 = decode |
| smp_stb | input | 1 | One sample or code per strobe |
| pcm_in | input | 8 | Signed sample to encode |
| code_in | input | 4 | Code to decode: sign in bit 3, magnitude in bits 2:0 |
| code_out | output | 4 | Latest encoded code |
| code_valid | output | 1 | One-cycle pulse after an encode strobe |
| pcm_out | output | 8 | Decoded sample, unsigned with offset 128 |
| pcm_valid | output | 1 | One-cycle pulse after a decode strobe |

## Verification
The hardest states to reach are the two saturation limits of the predictor and the top clamp of the step index. From quiet speech, the predictor rarely drives into either limit or pushes the index to 33. The stimulus gets there with long runs of full-magnitude codes in each sign, and with alternating full-scale samples on the encoder side. A 16-bit LFSR code stream then walks the index through its whole range in both directions. Lock-step between encoder and decoder is shown by logging every encoder code with the expected reconstruction, then replaying the log into the decoder.

// File: rtl/adpcm4_pkg.sv
package adpcm4_pkg;

   localparam int STEP_N = 34;
   localparam int IDX_W  = $clog2(STEP_N);
   localparam int JMP_W  = 5;

   typedef logic [IDX_W-1:0] idx_t;

   typedef enum logic {
      DIR_ENC = 1'b0,
      DIR_DEC = 1'b1
   } dir_e;

   // geometric step table, integer units
   function automatic logic [6:0] step_lut(input idx_t i);
      logic [6:0] v;
      case (i)
         6'd0:  v = 7'd7;    6'd1:  v = 7'd8;    6'd2:  v = 7'd8;
         6'd3:  v = 7'd9;    6'd4:  v = 7'd10;   6'd5:  v = 7'd11;
         6'd6:  v = 7'd12;   6'd7:  v = 7'd13;   6'd8:  v = 7'd14;
         6'd9:  v = 7'd15;   6'd10: v = 7'd17;   6'd11: v = 7'd18;
         6'd12: v = 7'd20;   6'd13: v = 7'd22;   6'd14: v = 7'd24;
         6'd15: v = 7'd26;   6'd16: v = 7'd29;   6'd17: v = 7'd31;
         6'd18: v = 7'd34;   6'd19: v = 7'd37;   6'd20: v = 7'd41;
         6'd21: v = 7'd44;   6'd22: v = 7'd48;   6'd23: v = 7'd53;
         6'd24: v = 7'd58;   6'd25: v = 7'd63;   6'd26: v = 7'd69;
         6'd27: v = 7'd75;   6'd28: v = 7'd82;   6'd29: v = 7'd89;
         6'd30: v = 7'd98;   6'd31: v = 7'd107;  6'd32: v = 7'd116;
         default: v = 7'd127;
      endcase
      return v;
   endfunction

   // index movement per code magnitude
   function automatic logic signed [JMP_W-1:0] idx_jump(input logic [2:0] mag);
      logic signed [JMP_W-1:0] j;
      case (mag)
         3'd4:    j = 5'sd2;
         3'd5:    j = 5'sd4;
         3'd6:    j = 5'sd6;
         3'd7:    j = 5'sd8;
         default: j = -5'sd1;
      endcase
      return j;
   endfunction

endpackage

// File: rtl/adpcm4_quant.sv
module adpcm4_quant #(
   parameter int ACC_W  = 18,
   parameter int MAG_W  = 3
) (
   input  logic signed [ACC_W-1:0] diff,
   input  logic        [ACC_W-1:0] step,
   output logic        [MAG_W:0]   code
);

   logic [ACC_W-1:0] rem;
   logic [ACC_W-1:0] thr;

   always_comb begin
      code          = '0;
      code[MAG_W]   = diff[ACC_W-1];
      rem           = diff[ACC_W-1] ? $unsigned(-diff) : $unsigned(diff);
      thr           = step;
      for (int b = MAG_W - 1; b >= 0; b--) begin
         if (rem >= thr) begin
            code[b] = 1'b1;
            rem     = rem - thr;
         end
         thr = thr >> 1;
      end
   end

endmodule

// File: rtl/adpcm4_track.sv
module adpcm4_track
   import adpcm4_pkg::*;
#(
   parameter int FRAC_W = 8,
   parameter int ACC_W  = 18,
   parameter int PMAX   = 127
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    upd,
   input  logic        [3:0]       code,
   output logic signed [ACC_W-1:0] pred_q,
   output logic        [ACC_W-1:0] step
);

   localparam logic signed [ACC_W-1:0] LIM_P = ACC_W'(PMAX * (2 ** FRAC_W));
   localparam logic signed [ACC_W-1:0] LIM_N = -LIM_P;
   localparam int                      WIDE_W = IDX_W + 2;
   localparam logic signed [WIDE_W-1:0] IDX_TOP = WIDE_W'(STEP_N - 1);

   idx_t                     idx_q;
   idx_t                     idx_d;
   logic signed [ACC_W-1:0]  pred_d;
   logic signed [ACC_W-1:0]  dq;
   logic signed [ACC_W-1:0]  sum;
   logic signed [JMP_W-1:0]  jmp5;
   logic signed [WIDE_W-1:0] jmp;
   logic signed [WIDE_W-1:0] wide;

   assign step = ACC_W'(step_lut(idx_q)) << FRAC_W;

   // reconstruction: shift-and-add with half-LSB bias
   always_comb begin
      dq = $signed(step >> 3);
      if (code[0]) dq = dq + $signed(step >> 2);
      if (code[1]) dq = dq + $signed(step >> 1);
      if (code[2]) dq = dq + $signed(step);
      sum = code[3] ? (pred_q - dq) : (pred_q + dq);
      if (sum > LIM_P)      pred_d = LIM_P;
      else if (sum < LIM_N) pred_d = LIM_N;
      else                  pred_d = sum;
   end

   // index adaptation with clamp
   always_comb begin
      jmp5 = idx_jump(code[2:0]);
      jmp  = {{(WIDE_W-JMP_W){jmp5[JMP_W-1]}}, jmp5};
      wide = $signed({2'b00, idx_q}) + jmp;
      if (wide < 0)            idx_d = '0;
      else if (wide > IDX_TOP) idx_d = idx_t'(STEP_N - 1);
      else                     idx_d = wide[IDX_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pred_q <= '0;
         idx_q  <= '0;
      end else if (clr) begin
         pred_q <= '0;
         idx_q  <= '0;
      end else if (upd) begin
         pred_q <= pred_d;
         idx_q  <= idx_d;
      end
   end

   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= idx_t'(STEP_N - 1)); // R6
   AST_IDX_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !clr && !code[2] && idx_q != '0) |=> (idx_q == $past(idx_q) - 1'b1)); // R6
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd && !clr) |=> ($stable(pred_q) && $stable(idx_q))); // R9
   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pred_q == '0 && idx_q == '0)); // R7

endmodule

// File: rtl/adpcm4_codec.sv
module adpcm4_codec
   import adpcm4_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int FRAC_W = 8,
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_start,
   input  logic              mode,
   input  logic              smp_stb,
   input  logic [DATA_W-1:0] pcm_in,
   input  logic [CODE_W-1:0] code_in,
   output logic [CODE_W-1:0] code_out,
   output logic              code_valid,
   output logic [DATA_W-1:0] pcm_out,
   output logic              pcm_valid
);

   localparam int ACC_W = DATA_W + FRAC_W + 2;
   localparam int PMAX  = 2 ** (DATA_W - 1) - 1;
   localparam int N_DIR = 2;
   localparam logic [DATA_W-1:0] MID = DATA_W'(2 ** (DATA_W - 1));
   localparam logic signed [ACC_W-1:0] LIM_P = ACC_W'(PMAX * (2 ** FRAC_W));
   localparam logic [ACC_W-1:0] STEP_LO = ACC_W'(7 * (2 ** FRAC_W));
   localparam logic [ACC_W-1:0] STEP_HI = ACC_W'(127 * (2 ** FRAC_W));

   if (DATA_W != 8) begin : g_bad_data
      $error("adpcm4_codec: step table is tuned for 8-bit samples");
   end
   if (FRAC_W < 3) begin : g_bad_frac
      $error("adpcm4_codec: FRAC_W must be at least 3 for exact step/8");
   end
   if (CODE_W != 4) begin : g_bad_code
      $error("adpcm4_codec: code width must be 4");
   end

   logic signed [ACC_W-1:0] pred_q [N_DIR];
   logic        [ACC_W-1:0] step_v [N_DIR];
   logic        [CODE_W-1:0] tcode [N_DIR];
   logic                    clr    [N_DIR];
   logic                    upd    [N_DIR];

   logic signed [ACC_W-1:0] smp_fx;
   logic signed [ACC_W-1:0] enc_diff;
   logic        [CODE_W-1:0] enc_code;

   assign smp_fx   = {{(ACC_W-DATA_W-FRAC_W){pcm_in[DATA_W-1]}}, pcm_in, {FRAC_W{1'b0}}};
   assign enc_diff = smp_fx - pred_q[DIR_ENC];

   adpcm4_quant #(.ACC_W(ACC_W), .MAG_W(CODE_W-1)) u_quant (
      .diff (enc_diff),
      .step (step_v[DIR_ENC]),
      .code (enc_code)
   );

   assign tcode[DIR_ENC] = enc_code;
   assign tcode[DIR_DEC] = code_in;

   for (genvar gd = 0; gd < N_DIR; gd++) begin : g_dir
      localparam logic SEL = (gd == 1);

      assign clr[gd] = run_start && (mode == SEL);
      assign upd[gd] = smp_stb && !run_start && (mode == SEL);

      adpcm4_track #(.FRAC_W(FRAC_W), .ACC_W(ACC_W), .PMAX(PMAX)) u_track (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (clr[gd]),
         .upd    (upd[gd]),
         .code   (tcode[gd]),
         .pred_q (pred_q[gd]),
         .step   (step_v[gd])
      );

      AST_PRED_SAT: assert property (@(posedge clk) disable iff (!rst_n)
         (pred_q[gd] <= LIM_P) && (pred_q[gd] >= -LIM_P)); // R5
      AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         (step_v[gd] >= STEP_LO) && (step_v[gd] <= STEP_HI)); // R6
   end

   // decoded level follows the decoder predictor
   assign pcm_out = pred_q[DIR_DEC][FRAC_W +: DATA_W] + MID;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_out   <= '0;
         code_valid <= 1'b0;
         pcm_valid  <= 1'b0;
      end else begin
         code_valid <= upd[DIR_ENC];
         pcm_valid  <= upd[DIR_DEC];
         if (upd[DIR_ENC]) code_out <= enc_code;
      end
   end

   AST_ENC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && !run_start && !mode) |=> code_valid); // R9
   AST_DEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && !run_start && mode) |=> pcm_valid); // R8
   AST_ONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({code_valid, pcm_valid})); // R9
   AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(smp_stb && !run_start && !mode) |=> $stable(code_out)); // R9
   AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      run_start |=> (!code_valid && !pcm_valid)); // R7
   AST_PCM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_out != '0); // R5

endmodule

// File: tb/adpcm4_codec_test.sv
module adpcm4_codec_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run_start = 1'b0;
   logic       mode = 1'b0;
   logic       smp_stb = 1'b0;
   logic [7:0] pcm_in = '0;
   logic [3:0] code_in = '0;
   logic [3:0] code_out;
   logic       code_valid;
   logic [7:0] pcm_out;
   logic       pcm_valid;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   int m_pred [2];
   int m_idx  [2];
   int enc_log [1024];
   int rec_log [1024];
   int n_log = 0;
   logic [15:0] lf = 16'hACE1;

   adpcm4_codec uut (
      .clk(clk), .rst_n(rst_n), .run_start(run_start), .mode(mode),
      .smp_stb(smp_stb), .pcm_in(pcm_in), .code_in(code_in),
      .code_out(code_out), .code_valid(code_valid),
      .pcm_out(pcm_out), .pcm_valid(pcm_valid)
   );

   always #5 clk = ~clk;

   function automatic int tbl(input int i);
      int t[34] = '{7,8,8,9,10,11,12,13,14,15,17,18,20,22,24,26,29,31,34,37,
                    41,44,48,53,58,63,69,75,82,89,98,107,116,127};
      return t[i];
   endfunction

   function automatic int level(input int p);
      return (p >>> 8) + 128;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic model_update(input int dir, input int c);
      int st, dq, mag;
      st  = tbl(m_idx[dir]) * 256;
      mag = c & 7;
      dq  = st / 8;
      if (c & 1) dq += st / 4;
      if (c & 2) dq += st / 2;
      if (c & 4) dq += st;
      m_pred[dir] = (c & 8) ? m_pred[dir] - dq : m_pred[dir] + dq;
      if (m_pred[dir] > 32512)  m_pred[dir] = 32512;
      if (m_pred[dir] < -32512) m_pred[dir] = -32512;
      m_idx[dir] += (mag < 4) ? -1 : 2 * (mag - 3);
      if (m_idx[dir] < 0)  m_idx[dir] = 0;
      if (m_idx[dir] > 33) m_idx[dir] = 33;
   endtask

   function automatic int model_code(input int s);
      int d, a, st, c;
      st = tbl(m_idx[0]) * 256;
      d  = s * 256 - m_pred[0];
      c  = (d < 0) ? 8 : 0;
      a  = (d < 0) ? -d : d;
      if (a >= st)     begin c += 4; a -= st;     end
      if (a >= st / 2) begin c += 2; a -= st / 2; end
      if (a >= st / 4) c += 1;
      return c;
   endfunction

   task automatic start(input logic m);
      @(negedge clk);
      mode = m; run_start = 1'b1;
      @(negedge clk);
      run_start = 1'b0;
      m_pred[m] = 0; m_idx[m] = 0;
   endtask

   task automatic enc(input int s, input bit log_it);
      int e;
      @(negedge clk);
      pcm_in = s[7:0]; mode = 1'b0; smp_stb = 1'b1;
      @(negedge clk);
      smp_stb = 1'b0;
      e = model_code(s);
      model_update(0, e);
      check(code_valid === 1'b1, "R9 code_valid", int'(code_valid), 1);
      check(code_out === e[3:0], "R2 R3 code", int'(code_out), e);
      if (log_it && n_log < 1024) begin
         enc_log[n_log] = e;
         rec_log[n_log] = level(m_pred[0]);
         n_log++;
      end
   endtask

   task automatic dec(input int c, input string req);
      @(negedge clk);
      code_in = c[3:0]; mode = 1'b1; smp_stb = 1'b1;
      @(negedge clk);
      smp_stb = 1'b0;
      model_update(1, c);
      check(pcm_valid === 1'b1, "R8 pcm_valid", int'(pcm_valid), 1);
      check(int'(pcm_out) == level(m_pred[1]), req, int'(pcm_out), level(m_pred[1]));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; vectors++;
         $display("FAIL watchdog R1: actual 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin : main
      m_pred[0] = 0; m_pred[1] = 0; m_idx[0] = 0; m_idx[1] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(code_out == 4'd0, "R1 code_out", int'(code_out), 0);
      check(code_valid == 1'b0, "R1 code_valid", int'(code_valid), 0);
      check(pcm_valid == 1'b0, "R1 pcm_valid", int'(pcm_valid), 0);
      check(pcm_out == 8'd128, "R1 pcm_out", int'(pcm_out), 128);

      // encoder sweeps, logged for replay (R2 R3 R4)
      start(1'b0);
      for (int s = -128; s < 128; s++) enc(s, 1'b1);
      for (int k = 0; k < 60; k++) enc((k % 2) ? 127 : -128, 1'b1);
      for (int k = 0; k < 40; k++) enc(0, 1'b1);
      for (int s = 127; s >= -128; s -= 3) enc(s, 1'b1);

      // R10 lock-step: replay encoder codes into decoder
      start(1'b1);
      for (int k = 0; k < n_log; k++) begin
         dec(enc_log[k], "R4 decode");
         check(int'(pcm_out) == rec_log[k], "R10 lock-step", int'(pcm_out), rec_log[k]);
      end

      // R10 isolation: interleave modes
      start(1'b0);
      for (int k = 0; k < 20; k++) enc(k * 11 - 100, 1'b0);
      for (int k = 0; k < 10; k++) dec(k, "R10 decode between encodes");
      for (int k = 0; k < 20; k++) enc(90 - k * 9, 1'b0);

      // R5 saturation and R6 index top clamp
      start(1'b1);
      for (int k = 0; k < 40; k++) dec(7, "R6 rising");
      check(pcm_out == 8'd255, "R5 upper limit", int'(pcm_out), 255);
      for (int k = 0; k < 40; k++) dec(15, "R6 falling");
      check(pcm_out == 8'd1, "R5 lower limit", int'(pcm_out), 1);

      // R6 pseudo-random code walk
      for (int k = 0; k < 1500; k++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         dec(int'(lf[3:0]), "R6 adapt walk");
      end

      // R7 restart of decoder only, strobe in same cycle ignored
      @(negedge clk);
      mode = 1'b1; run_start = 1'b1; smp_stb = 1'b1; code_in = 4'd7;
      @(negedge clk);
      run_start = 1'b0; smp_stb = 1'b0;
      m_pred[1] = 0; m_idx[1] = 0;
      check(pcm_valid == 1'b0, "R7 strobe ignored", int'(pcm_valid), 0);
      check(pcm_out == 8'd128, "R7 decoder cleared", int'(pcm_out), 128);
      for (int k = 0; k < 10; k++) enc(50 - k * 13, 1'b0); // R7 encoder state kept
      dec(3, "R7 decoder from zero");

      // R9 idle: no strobe, nothing moves
      begin
         logic [3:0] hold_c;
         logic [7:0] hold_p;
         hold_c = code_out; hold_p = pcm_out;
         pcm_in = 8'h80; code_in = 4'hF;
         repeat (6) @(negedge clk);
         check(code_valid == 1'b0, "R9 idle code_valid", int'(code_valid), 0);
         check(pcm_valid == 1'b0, "R9 idle pcm_valid", int'(pcm_valid), 0);
         check(code_out == hold_c, "R9 code_out held", int'(code_out), int'(hold_c));
         check(pcm_out == hold_p, "R9 pcm_out held", int'(pcm_out), int'(hold_p));
      end
      enc(-77, 1'b0); // R9 encoder state unchanged by idle cycles

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule